// File: doc/BRIEF.md
# Selectable Multi-Channel Debounce Filter

This block removes contact bounce from a group of sensor lines that already arrive as logic levels. Every channel has its own filter: a raw line is first brought into the clock domain through a two-flop synchronizer, and its level is accepted as the new clean value only after it has stayed different from the current clean value across a selected number of 1 ms timebase ticks. The clean outputs are meant to feed the parallel inputs of a serializer.

One 2-bit select code governs all channels together. It chooses a long window of three ticks, a short window of one tick, or a bypass in which the clean outputs track the synchronized inputs on every clock. The fourth code is reserved and is treated as the long window, so a wrong strap never weakens the filtering. The select code is sampled only on tick cycles, so a change takes effect at a tick boundary and never disturbs an output in between. The timebase tick is a one-clock pulse supplied from outside.

Top module: `multi_debounce`

## Requirements
- R1: While reset is asserted and right after its release, every clean output is 0 and every stability counter is cleared.
- R2: Each raw input passes through two synchronizer flops; in bypass a raw change made before clock edge A shows on the clean output after edge A+2, and not after A or A+1.
- R3: Select code 2'b11 (sel[1]=1, sel[0]=1) makes a bit change on the third consecutive tick at which the synchronized input differs from the clean output, and not on the first or second.
- R4: Select code 2'b10 makes a bit take the synchronized level on the first tick at which the two differ.
- R5: Select code 2'b01 is bypass: each clean bit takes the synchronized level on every clock edge, with or without ticks.
- R6: Select code 2'b00 is reserved and behaves exactly like code 2'b11.
- R7: When the synchronized input returns to the clean level before the window completes, the count restarts, and a later change again needs the full number of ticks.
- R8: Filtering is symmetric: rising and falling changes need the same number of ticks.
- R9: Every channel has its own counter; changes on one channel neither advance nor reset the count of another.
- R10: The select code is read only on a tick cycle; a code read at a tick already governs that tick, and a change between ticks has no effect on any output.
- R11: Outside bypass, a clean output can change only at a clock edge on which the tick is high.
- R12: A clean bit only ever changes to the synchronized level of its own input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously to clk |
| tick_1ms | input | 1 | One-cycle pulse marking each 1 ms timebase step |
| sel | input | 2 | Window select: 11 three ticks, 10 one tick, 01 bypass, 00 reserved (three ticks) |
| raw_in | input | CHANNELS | Unfiltered sensor levels, asynchronous to clk |
| clean_out | output | CHANNELS | Debounced channel levels |

## Verification
On every cycle the assertions check the reset value, that outputs move only on tick edges unless bypass is active, that bypass tracks the raw levels with a two-edge delay, that the one-tick window accepts any difference at once, and that a bit never moves away from its own synchronized level. The exact tick count of the three-tick window, the restart after a bounce, the reserved code, the independence of channels and the moment a new select code starts to apply are shown only by the bench scenarios, which count ticks against known input histories and sweep all 256 input patterns in the bypass and one-tick modes.

// File: rtl/dbn_pkg.sv
package dbn_pkg;

  // Select code values; bit 1 and bit 0 are decoded together.
  localparam logic [1:0] SEL_LONG   = 2'b11;
  localparam logic [1:0] SEL_SHORT  = 2'b10;
  localparam logic [1:0] SEL_BYPASS = 2'b01;
  localparam logic [1:0] SEL_RSVD   = 2'b00;

  typedef enum logic [1:0] {
    MODE_BYPASS = 2'd0,
    MODE_SHORT  = 2'd1,
    MODE_LONG   = 2'd2
  } dbn_mode_e;

  // Reserved code falls back to the long window.
  function automatic dbn_mode_e decode_sel(input logic [1:0] code);
    dbn_mode_e m;
    case (code)
      SEL_SHORT:  m = MODE_SHORT;
      SEL_BYPASS: m = MODE_BYPASS;
      default:    m = MODE_LONG;
    endcase
    return m;
  endfunction

endpackage

// File: rtl/dbn_sync.sv
module dbn_sync #(
  parameter int WIDTH  = 8,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);

  logic [STAGES-1:0][WIDTH-1:0] stage_q;
  logic [STAGES-1:0][WIDTH-1:0] stage_d;

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      assign stage_d[g] = din;
    end else begin : g_next
      assign stage_d[g] = stage_q[g-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= '0;
    end else begin
      stage_q <= stage_d;
    end
  end

  assign dout = stage_q[STAGES-1];

endmodule

// File: rtl/dbn_mode_ctl.sv
module dbn_mode_ctl
  import dbn_pkg::*;
#(
  parameter int SHORT_TICKS = 1,
  parameter int LONG_TICKS  = 3,
  localparam int CNT_W      = $clog2(LONG_TICKS + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_1ms,
  input  logic [1:0]       sel,
  output logic             eff_bypass,
  output logic [CNT_W-1:0] eff_limit
);

  dbn_mode_e active_q;
  dbn_mode_e active_d;

  // The code is sampled on tick cycles and governs that same tick.
  always_comb begin
    active_d = active_q;
    if (tick_1ms) begin
      active_d = decode_sel(sel);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= MODE_LONG;
    end else begin
      active_q <= active_d;
    end
  end

  always_comb begin
    eff_bypass = (active_d == MODE_BYPASS);
    if (active_d == MODE_SHORT) begin
      eff_limit = CNT_W'(SHORT_TICKS);
    end else begin
      eff_limit = CNT_W'(LONG_TICKS);
    end
  end

endmodule

// File: rtl/dbn_channel.sv
module dbn_channel #(
  parameter int CNT_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_1ms,
  input  logic             bypass,
  input  logic [CNT_W-1:0] limit,
  input  logic             sync_in,
  output logic             clean
);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             out_q, out_d;
  logic [CNT_W:0]   cnt_inc;

  assign cnt_inc = {1'b0, cnt_q} + 1'b1;

  always_comb begin
    cnt_d = cnt_q;
    out_d = out_q;
    if (bypass) begin
      out_d = sync_in;
      cnt_d = '0;
    end else if (sync_in == out_q) begin
      cnt_d = '0;
    end else if (tick_1ms) begin
      if (cnt_inc >= {1'b0, limit}) begin
        out_d = sync_in;
        cnt_d = '0;
      end else begin
        cnt_d = cnt_inc[CNT_W-1:0];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      out_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      out_q <= out_d;
    end
  end

  assign clean = out_q;

endmodule

// File: rtl/multi_debounce.sv
module multi_debounce #(
  parameter int CHANNELS    = 8,
  parameter int SYNC_STAGES = 2,
  parameter int SHORT_TICKS = 1,
  parameter int LONG_TICKS  = 3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                tick_1ms,
  input  logic [1:0]          sel,
  input  logic [CHANNELS-1:0] raw_in,
  output logic [CHANNELS-1:0] clean_out
);

  localparam int CNT_W = $clog2(LONG_TICKS + 1);

  logic [CHANNELS-1:0] sync_lvl;
  logic                eff_bypass;
  logic [CNT_W-1:0]    eff_limit;

  dbn_sync #(
    .WIDTH  (CHANNELS),
    .STAGES (SYNC_STAGES)
  ) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .din   (raw_in),
    .dout  (sync_lvl)
  );

  dbn_mode_ctl #(
    .SHORT_TICKS (SHORT_TICKS),
    .LONG_TICKS  (LONG_TICKS)
  ) u_mode (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick_1ms   (tick_1ms),
    .sel        (sel),
    .eff_bypass (eff_bypass),
    .eff_limit  (eff_limit)
  );

  for (genvar c = 0; c < CHANNELS; c++) begin : g_chan
    dbn_channel #(
      .CNT_W (CNT_W)
    ) u_chan (
      .clk      (clk),
      .rst_n    (rst_n),
      .tick_1ms (tick_1ms),
      .bypass   (eff_bypass),
      .limit    (eff_limit),
      .sync_in  (sync_lvl[c]),
      .clean    (clean_out[c])
    );
  end

endmodule

// File: rtl/dbn_checker.sv
module dbn_checker #(
  parameter int CHANNELS = 8
) (
  input logic                clk,
  input logic                rst_n,
  input logic                tick_1ms,
  input logic [1:0]          sel,
  input logic [CHANNELS-1:0] raw_in,
  input logic [CHANNELS-1:0] clean_out
);

  logic                byp_q;
  logic [CHANNELS-1:0] p1_q, p2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      byp_q <= 1'b0;
      p1_q  <= '0;
      p2_q  <= '0;
    end else begin
      p1_q <= raw_in;
      p2_q <= p1_q;
      if (tick_1ms) begin
        byp_q <= (sel == 2'b01);
      end
    end
  end

  // R1
  reset_zero_chk: assert property (@(posedge clk) $rose(rst_n) |-> (clean_out == '0));

  // R11
  tick_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick_1ms && !byp_q) |=> $stable(clean_out));

  // R5
  bypass_track_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((tick_1ms && sel == 2'b01) || (!tick_1ms && byp_q)) |=> (clean_out == $past(p2_q)));

  // R4
  short_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_1ms && sel == 2'b10) |=> (clean_out == $past(p2_q)));

  // R12
  toward_input_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> (((clean_out ^ $past(clean_out)) & (clean_out ^ $past(p2_q))) == '0));

endmodule

bind multi_debounce dbn_checker #(.CHANNELS(CHANNELS)) u_dbn_checker (
  .clk       (clk),
  .rst_n     (rst_n),
  .tick_1ms  (tick_1ms),
  .sel       (sel),
  .raw_in    (raw_in),
  .clean_out (clean_out)
);

// File: tb/test_multi_debounce.sv
module test_multi_debounce;

  localparam int CH = 8;

  logic          clk;
  logic          rst_n;
  logic          tick_1ms;
  logic [1:0]    sel;
  logic [CH-1:0] raw_in;
  logic [CH-1:0] clean_out;

  int checks;
  int errors;
  bit done;

  multi_debounce #(.CHANNELS(CH)) i_multi_debounce (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick_1ms  (tick_1ms),
    .sel       (sel),
    .raw_in    (raw_in),
    .clean_out (clean_out)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic edges(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // One tick pulse; returns at the negedge after the tick edge.
  task automatic tick();
    tick_1ms = 1'b1;
    @(negedge clk);
    tick_1ms = 1'b0;
  endtask

  task automatic drive(input logic [CH-1:0] v);
    raw_in = v;
    edges(3);
  endtask

  task automatic check(input string req, input logic [CH-1:0] exp);
    checks++;
    if (clean_out !== exp) begin
      errors++;
      $display("FAIL %s: clean_out=%h expected=%h", req, clean_out, exp);
    end
  endtask

  initial begin
    rst_n = 1'b0; tick_1ms = 1'b0; sel = 2'b11; raw_in = '0;
    checks = 0; errors = 0; done = 1'b0;
    edges(3);
    check("R1", 8'h00);
    rst_n = 1'b1;
    edges(1);
    check("R1", 8'h00);

    // R3: three-tick window, rising
    sel = 2'b11;
    drive(8'hA5);
    tick(); check("R3", 8'h00);
    tick(); check("R3", 8'h00);
    tick(); check("R3", 8'hA5);

    // R8: falling needs the same count
    drive(8'h00);
    tick(); check("R8", 8'hA5);
    tick(); check("R8", 8'hA5);
    tick(); check("R8", 8'h00);

    // R9: staggered channels count independently
    drive(8'h01);
    tick(); tick();
    drive(8'h03);
    tick(); check("R9", 8'h01);
    tick(); check("R9", 8'h01);
    tick(); check("R9", 8'h03);

    // R6: reserved code acts as three ticks
    sel = 2'b00;
    drive(8'h00);
    tick(); check("R6", 8'h03);
    tick(); check("R6", 8'h03);
    tick(); check("R6", 8'h00);

    // R4: one-tick window
    sel = 2'b10;
    drive(8'h3C);
    tick(); check("R4", 8'h3C);

    // R7: bounce restarts the count
    sel = 2'b11;
    drive(8'hFF);
    tick(); tick();
    drive(8'h3C);
    tick(); check("R7", 8'h3C);
    drive(8'hFF);
    tick(); tick(); check("R7", 8'h3C);
    tick(); check("R7", 8'hFF);

    // R10: code change between ticks has no effect
    sel = 2'b01;
    drive(8'h00);
    edges(5);
    check("R10", 8'hFF);
    sel = 2'b10;
    edges(2);
    check("R10", 8'hFF);
    tick(); check("R10", 8'h00);

    // R2: bypass latency through two synchronizer flops
    sel = 2'b01;
    tick(); check("R5", 8'h00);
    raw_in = 8'h81;
    edges(1); check("R2", 8'h00);
    edges(1); check("R2", 8'h00);
    edges(1); check("R2", 8'h81);
    // R5: bypass needs no tick
    drive(8'h7E);
    check("R5", 8'h7E);

    // R5 sweep of every pattern in bypass
    for (int v = 0; v < 256; v++) begin
      drive(v[CH-1:0]);
      check("R5", v[CH-1:0]);
    end

    // R4 sweep of every pattern in the one-tick window
    sel = 2'b10;
    tick();
    for (int v = 0; v < 256; v++) begin
      logic [CH-1:0] pat;
      pat = v[CH-1:0] ^ 8'h5A;
      drive(pat);
      tick();
      check("R4", pat);
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    for (int i = 0; i < 200000; i++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: finished=0 expected=1");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule